// File: doc/BRIEF.md
# Refresh-Cycle Character Generator

This block is the character datapath of a display scheme in which an 8-bit CPU runs the display file as if it were code. It watches opcode fetches from the upper half of memory while the display is enabled. At the T2 strobe of such a fetch it captures the character code. When bit 6 of that code is clear, it forces the CPU data bus to zero, so the CPU decodes a NOP in place of the code.

During the refresh half of the same machine cycle, the block drives the ten low address lines with the character-generator address. The row counter supplies the three lowest bits, the six code bits come next, and bit 9 comes either from the CPU's own A9 or, in extended-character mode, from its refresh-time A8. The CPU's high address lines pass through unchanged. At the next T1 strobe the pattern byte on the memory bus is loaded into a shift register. Its eight pixels then leave MSB first on the pixel enable, and they are inverted when bit 7 of the code was set.

The system clock is faster than the CPU. All CPU timing arrives as single-cycle strobes (T1, T2, T3 and the pixel enable) plus level signals for M1 and refresh. The pixel enable runs at twice the CPU clock rate, so one character takes exactly four T-states.

Top module: `refresh_chargen`

## Requirements
- R1: At a clock edge with `t2_stb` high, `m1` high, `cpu_addr[15]` high and `disp_en` high (a display fetch), bits 5..0 and bit 7 of `mem_data` are captured. Bit 6 is not stored.
- R2: If bit 6 of the captured byte is 0, `data_zero` is high from the cycle after the T2 strobe up to and including the cycle that carries `t3_stb`. It is low again in the following cycle.
- R3: If bit 6 of a display fetch is 1 (for example a HALT opcode 0x76), `data_zero` stays low, no refresh address is driven and no pattern is loaded.
- R4: A fetch that is not a display fetch (`m1` low, `cpu_addr[15]` low or `disp_en` low) never raises `data_zero`, drives no address and loads no pattern.
- R5: After a captured character with bit 6 clear, `addr_drive` equals `rfsh` until the next T1 strobe. While it is high, `addr_out[2:0]` = `row`, `addr_out[8:3]` = code bits 5..0 and `addr_out[9]` = `cpu_addr[9]`.
- R6: With `ext_chr` high, `addr_out[9]` takes `cpu_addr[8]` instead of `cpu_addr[9]`.
- R7: At the T1 strobe that follows such a capture, `mem_data` is loaded as the pattern byte. Its bit 7 appears on `video` in the very next cycle.
- R8: Each later `pix_en` pulse moves to the next lower pattern bit, so the 8 pixels leave MSB first, one for every two system cycles of the bench timing.
- R9: If code bit 7 was 1, every pixel of that character is inverted on `video`.
- R10: After reset, and once all 8 pixels of a character have been shifted out, `video` is 0 (background) and `data_zero` and `addr_drive` are low.
- R11: Back-to-back display characters give continuous video. The last pixel of one character is followed directly by the first pixel of the next, with no background gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| t1_stb | input | 1 | One-cycle strobe at the start of T1 |
| t2_stb | input | 1 | One-cycle strobe at the start of T2 |
| t3_stb | input | 1 | One-cycle strobe at the start of T3 |
| pix_en | input | 1 | Pixel shift enable (twice the CPU clock rate) |
| m1 | input | 1 | Opcode fetch in progress, active high |
| rfsh | input | 1 | Refresh half of the fetch cycle, active high |
| disp_en | input | 1 | Display generation enabled |
| ext_chr | input | 1 | Extended-character mode: refresh A8 selects address bit 9 |
| row | input | 3 | Scan row within the character |
| cpu_addr | input | 16 | CPU address bus |
| mem_data | input | 8 | Memory data bus |
| data_zero | output | 1 | Force the CPU data lines to zero |
| addr_drive | output | 1 | Enable for the generated low address lines |
| addr_out | output | 10 | Generated character-generator address, bits 9..0 |
| video | output | 1 | Serial pixel output |

## Verification
The data-zero enable is due one system cycle after the T2 strobe edge, and it drops one cycle after the T3 strobe edge. The refresh address is combinational on `rfsh`, so it is checked in the middle of the refresh half. The first pixel is due in the cycle after the T1 load, and each further pixel follows one pixel-enable edge later. The bench therefore counts phases inside a 16-cycle machine cycle, drives inputs on the falling clock edge and samples each result in the phase where the count of registers places it: data zero in phases 5, 8 and 9, the address in phase 10, and pixels in the odd phases.

// File: rtl/refresh_chargen.sv
module refresh_chargen #(
  parameter int PAT_W = 8,
  parameter int ROW_W = 3,
  parameter int CODE_W = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          t1_stb,
  input  logic                          t2_stb,
  input  logic                          t3_stb,
  input  logic                          pix_en,
  input  logic                          m1,
  input  logic                          rfsh,
  input  logic                          disp_en,
  input  logic                          ext_chr,
  input  logic [ROW_W-1:0]              row,
  input  logic [15:0]                   cpu_addr,
  input  logic [PAT_W-1:0]              mem_data,
  output logic                          data_zero,
  output logic                          addr_drive,
  output logic [ROW_W+CODE_W:0]         addr_out,
  output logic                          video
);
  localparam int CNT_W = $clog2(PAT_W + 1);

  logic [CODE_W-1:0] chr_q;
  logic              chr_inv, armed, zero_q, pix_inv;
  logic [PAT_W-1:0]  shreg;
  logic [CNT_W-1:0]  vcnt;

  wire disp_fetch = m1 & cpu_addr[15] & disp_en;
  wire load       = t1_stb & armed;
  wire shift      = pix_en & (vcnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chr_q   <= '0;
      chr_inv <= 1'b0;
      armed   <= 1'b0;
      zero_q  <= 1'b0;
    end else begin
      if (t2_stb && disp_fetch) begin
        chr_q   <= mem_data[CODE_W-1:0];
        chr_inv <= mem_data[7];
        armed   <= ~mem_data[6];
        zero_q  <= ~mem_data[6];
      end else begin
        if (t3_stb) zero_q <= 1'b0;
        if (t1_stb) armed <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      vcnt    <= '0;
      pix_inv <= 1'b0;
    end else if (load) begin
      shreg   <= mem_data;
      vcnt    <= CNT_W'(PAT_W);
      pix_inv <= chr_inv;
    end else if (shift) begin
      shreg <= {shreg[PAT_W-2:0], 1'b0};
      vcnt  <= vcnt - 1'b1;
    end
  end

  assign data_zero  = zero_q;
  assign addr_drive = armed & rfsh;
  assign addr_out   = {(ext_chr ? cpu_addr[8] : cpu_addr[9]), chr_q, row};
  assign video      = (vcnt != '0) & (shreg[PAT_W-1] ^ pix_inv);

  // R2
  zero_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_zero) |-> $past(t2_stb && m1 && cpu_addr[15] && disp_en && !mem_data[6]));

  // R2
  zero_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t3_stb |=> !data_zero);

  // R4
  foreign_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t2_stb && !(m1 && cpu_addr[15] && disp_en) && !data_zero) |=> !data_zero);

  // R5
  addr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    t1_stb |=> !addr_drive);

  // R7
  load_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_stb && armed) |=> (vcnt == CNT_W'(PAT_W)));

  // R8
  shift_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_en && !t1_stb && vcnt != '0) |=> (vcnt == $past(vcnt) - 1'b1));

  // R10
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vcnt <= CNT_W'(PAT_W));
endmodule

// File: tb/test_refresh_chargen.sv
module test_refresh_chargen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic t1_stb = 0, t2_stb = 0, t3_stb = 0, pix_en = 0;
  logic m1 = 0, rfsh = 0, disp_en = 0, ext_chr = 0;
  logic [2:0] row = '0;
  logic [15:0] cpu_addr = '0;
  logic [7:0] mem_data = '0;
  logic data_zero, addr_drive, video;
  logic [9:0] addr_out;

  int checks = 0, errors = 0;
  logic pv_valid = 0, pv_inv = 0;

  refresh_chargen i_refresh_chargen (
    .clk(clk), .rst_n(rst_n), .t1_stb(t1_stb), .t2_stb(t2_stb), .t3_stb(t3_stb),
    .pix_en(pix_en), .m1(m1), .rfsh(rfsh), .disp_en(disp_en), .ext_chr(ext_chr),
    .row(row), .cpu_addr(cpu_addr), .mem_data(mem_data), .data_zero(data_zero),
    .addr_drive(addr_drive), .addr_out(addr_out), .video(video));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] exp_addr(input logic [7:0] code, input logic [2:0] r,
                                          input logic [15:0] ra, input logic ext);
    return {(ext ? ra[8] : ra[9]), code[5:0], r};
  endfunction

  function automatic logic exp_pix(input logic [7:0] pat, input int k, input logic inv, input logic valid);
    return valid ? (pat[7-k] ^ inv) : 1'b0;
  endfunction

  // One 16-cycle machine cycle: T1 loads the previous pattern, T2 fetches code.
  task automatic mcycle(input logic [7:0] code, input logic m1v, input logic a15v, input logic dispv,
                        input logic [7:0] pat, input logic [2:0] r, input logic [15:0] ra,
                        input logic ext);
    logic hit, nop;
    string ptag;
    hit = m1v & a15v & dispv;
    nop = hit & ~code[6];
    for (int p = 0; p < 16; p++) begin
      @(negedge clk);
      t1_stb = (p == 0); t2_stb = (p == 4); t3_stb = (p == 8);
      pix_en = (p % 2 == 0);
      m1 = (p < 8) ? m1v : 1'b0;
      rfsh = (p >= 8);
      disp_en = dispv; ext_chr = ext; row = r;
      cpu_addr = (p < 8) ? {a15v, 15'h1234} : ra;
      mem_data = (p == 0) ? pat : code;
      #1;
      if (p % 2 == 1) begin
        ptag = !pv_valid ? "R10" : (p == 1) ? "R7" : (p == 15) ? "R11" : pv_inv ? "R9" : "R8";
        chk(ptag, 16'(video), 16'(exp_pix(pat, (p - 1) / 2, pv_inv, pv_valid)));
      end
      if (p == 5 || p == 8)
        chk(!hit ? "R4" : code[6] ? "R3" : "R2", 16'(data_zero), 16'(nop));
      if (p == 9) chk("R2", 16'(data_zero), 16'd0);
      if (p == 2) chk("R5", 16'(addr_drive), 16'd0);
      if (p == 10) begin
        chk(!hit ? "R4" : code[6] ? "R3" : "R5", 16'(addr_drive), 16'(nop));
        if (nop) chk(ext ? "R6" : "R1", 16'(addr_out), 16'(exp_addr(code, r, ra, ext)));
      end
    end
    pv_valid = nop;
    pv_inv = code[7];
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4217));
    repeat (3) @(negedge clk);
    #1;
    chk("R10", 16'(video), 16'd0);
    chk("R10", 16'(data_zero), 16'd0);
    chk("R10", 16'(addr_drive), 16'd0);
    rst_n = 1'b1;

    // directed: plain, inverted (back-to-back), halt, foreign fetches, extended mode
    mcycle(8'h26, 1, 1, 1, 8'h00, 3'd2, 16'h1E55, 0);
    mcycle(8'hA6, 1, 1, 1, 8'h81, 3'd5, 16'h1DAA, 0);
    mcycle(8'h76, 1, 1, 1, 8'hC3, 3'd0, 16'h1E00, 0);
    mcycle(8'h15, 1, 0, 1, 8'hFF, 3'd1, 16'h1E00, 0);
    mcycle(8'h15, 1, 1, 0, 8'hFF, 3'd1, 16'h1E00, 0);
    mcycle(8'h15, 0, 1, 1, 8'hFF, 3'd1, 16'h1E00, 0);
    mcycle(8'h3F, 1, 1, 1, 8'hFF, 3'd7, 16'h1D00, 1);
    mcycle(8'h80, 1, 1, 1, 8'h5A, 3'd3, 16'h1E80, 1);
    mcycle(8'h00, 0, 0, 0, 8'hA5, 3'd0, 16'h0000, 0);
    mcycle(8'h00, 0, 0, 0, 8'hFF, 3'd0, 16'h0000, 0);

    for (int n = 0; n < 400; n++) begin
      logic [7:0] c;
      logic dm;
      c = 8'($urandom);
      dm = ($urandom % 8) != 0;
      mcycle(c, dm | 1'($urandom), dm | 1'($urandom), dm | 1'($urandom), 8'($urandom),
             3'($urandom), 16'($urandom), 1'($urandom));
    end
    mcycle(8'h00, 0, 0, 0, 8'h3C, 3'd0, 16'h0000, 0);
    mcycle(8'h00, 0, 0, 0, 8'h3C, 3'd0, 16'h0000, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule